// File: doc/BRIEF.md
# ADC Window Monitor

This block watches the stream of finished analog-to-digital conversions and raises an alarm when a result leaves a programmable window. Each conversion arrives as a one-cycle valid pulse that carries the channel number and a 16-bit result word. Only the low 12 bits of that word hold the conversion value. The block decides whether the channel is being watched. It can watch one chosen channel or every channel. It then compares the value with an upper limit and a lower limit, and each of those comparisons has its own enable.

A value outside the window sets a sticky raw flag for the side that was crossed. Each raw flag is ANDed with its own interrupt-enable bit to give a masked interrupt, and the two masked interrupts are also ORed onto a single interrupt line. Software clears the raw flags with a one-cycle clear pulse and a two-bit mask. All outputs are registered, and reset is synchronous and active high.

Top module: `adc_window_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, all five outputs are 0.
- R2: A valid, monitored result whose low 12 bits are strictly greater than `cfg_hi_limit`, with `cfg_hi_chk` set, makes `raw_hi` 1 after the clock edge that samples it.
- R3: A valid, monitored result whose low 12 bits are strictly less than `cfg_lo_limit`, with `cfg_lo_chk` set, makes `raw_lo` 1 after the clock edge that samples it.
- R4: The comparisons are unsigned and strict. A result equal to a limit sets no flag.
- R5: While `cfg_hi_chk` is 0, no result sets `raw_hi`. While `cfg_lo_chk` is 0, no result sets `raw_lo`.
- R6: With `cfg_all_chan` at 0, only results whose `res_chan` equals `cfg_chan_sel` are compared. Results from other channels leave both raw flags unchanged.
- R7: With `cfg_all_chan` at 1, results from every channel are compared, whatever `cfg_chan_sel` holds.
- R8: A raw flag stays at 1 until a clock edge that samples `clr_stb` high with that flag's mask bit set. Mask bit 1 clears `raw_hi` and mask bit 0 clears `raw_lo`. A flag whose mask bit is 0 is not affected.
- R9: When a violation and a clear of the same flag arrive on the same edge, the flag ends up set.
- R10: `irq_hi` equals `raw_hi` AND `cfg_ie_hi`, and `irq_lo` equals `raw_lo` AND `cfg_ie_lo`. `irq` is the OR of the two. A change of an enable shows at the outputs after the next clock edge.
- R11: Bits 15:12 of `res_data` play no part in either comparison.
- R12: While `res_valid` is 0, the result inputs have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle strobe marking a finished conversion |
| res_chan | input | CHAN_W | Channel that produced the result |
| res_data | input | WORD_W | Result word; the value is in the low DATA_W bits |
| cfg_hi_limit | input | DATA_W | Upper limit of the window |
| cfg_lo_limit | input | DATA_W | Lower limit of the window |
| cfg_hi_chk | input | 1 | Enables the upper comparison |
| cfg_lo_chk | input | 1 | Enables the lower comparison |
| cfg_chan_sel | input | CHAN_W | Channel watched when `cfg_all_chan` is 0 |
| cfg_all_chan | input | 1 | Watches every channel |
| cfg_ie_hi | input | 1 | Interrupt enable for the upper flag |
| cfg_ie_lo | input | 1 | Interrupt enable for the lower flag |
| clr_stb | input | 1 | Clear pulse for the raw flags |
| clr_mask | input | 2 | Flags to clear: bit 1 upper, bit 0 lower |
| raw_hi | output | 1 | Sticky flag for a result above the window |
| raw_lo | output | 1 | Sticky flag for a result below the window |
| irq_hi | output | 1 | Masked upper interrupt |
| irq_lo | output | 1 | Masked lower interrupt |
| irq | output | 1 | OR of the two masked interrupts |

## Verification
Every flag and interrupt output is due one clock edge after the edge that samples the result, the clear pulse or an enable change. Nothing in the block takes longer than that. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and compares all five outputs at that moment. This is exactly one rising edge after the stimulus was sampled. Persistence checks look again after further idle or in-window cycles, which confirms that a flag neither decays nor sets late.

// File: rtl/adcwm_pkg.sv
package adcwm_pkg;

  // Index of each side of the window in per-side vectors.
  localparam int SIDE_LO = 0;
  localparam int SIDE_HI = 1;
  localparam int N_SIDE  = 2;

  // True when the side flags results that exceed its limit.
  function automatic bit side_is_upper(int side);
    return side == SIDE_HI;
  endfunction

endpackage

// File: rtl/adcwm_chan_filter.sv
module adcwm_chan_filter #(
  parameter int CHAN_W = 4
) (
  input  logic              valid_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [CHAN_W-1:0] sel_i,
  input  logic              all_i,
  output logic              accept_o
);

  logic chan_match;

  always_comb begin
    chan_match = (chan_i == sel_i);
    accept_o   = valid_i & (all_i | chan_match);
  end

endmodule

// File: rtl/adcwm_limit_cmp.sv
module adcwm_limit_cmp #(
  parameter int WORD_W = 16,
  parameter bit UPPER  = 1'b1
) (
  input  logic              accept_i,
  input  logic              enable_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic [WORD_W-1:0] limit_i,
  output logic              hit_o
);

  logic beyond;

  // The parameter picks the direction of the strict comparison.
  generate
    if (UPPER) begin : g_above
      always_comb beyond = (sample_i > limit_i);
    end else begin : g_below
      always_comb beyond = (sample_i < limit_i);
    end
  endgenerate

  always_comb hit_o = accept_i & enable_i & beyond;

endmodule

// File: rtl/adcwm_flag_cell.sv
module adcwm_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic raw_next_o,
  output logic raw_q_o,
  output logic irq_q_o
);

  // A set on the same edge as a clear wins.
  always_comb raw_next_o = set_i | (raw_q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q_o <= 1'b0;
      irq_q_o <= 1'b0;
    end else begin
      raw_q_o <= raw_next_o;
      irq_q_o <= raw_next_o & ien_i;
    end
  end

  // R8: a set flag holds unless it is cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (raw_q_o && !clr_i) |=> raw_q_o);

  // R8: a clear without a set drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !raw_q_o);

  // R9: a violation beats a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> raw_q_o);

  // R10: a masked interrupt never shows without its raw flag
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q_o |-> raw_q_o);

endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import adcwm_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int DATA_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [WORD_W-1:0] res_data,
  input  logic [DATA_W-1:0] cfg_hi_limit,
  input  logic [DATA_W-1:0] cfg_lo_limit,
  input  logic              cfg_hi_chk,
  input  logic              cfg_lo_chk,
  input  logic [CHAN_W-1:0] cfg_chan_sel,
  input  logic              cfg_all_chan,
  input  logic              cfg_ie_hi,
  input  logic              cfg_ie_lo,
  input  logic              clr_stb,
  input  logic [1:0]        clr_mask,
  output logic              raw_hi,
  output logic              raw_lo,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              irq
);

  localparam int PAD_W = WORD_W - DATA_W;
  localparam logic [WORD_W-1:0] VALUE_MASK = {{PAD_W{1'b0}}, {DATA_W{1'b1}}};

  logic [WORD_W-1:0] sample_w;
  logic              accept;
  logic [N_SIDE-1:0] chk_en, ien, clr_sel, hit, raw_next, raw_q, irq_q;
  logic [WORD_W-1:0] limit_w [N_SIDE];
  logic              irq_q_any;

  // Only the right-aligned value takes part in the comparisons.
  always_comb sample_w = res_data & VALUE_MASK;

  always_comb begin
    chk_en[SIDE_HI]  = cfg_hi_chk;
    chk_en[SIDE_LO]  = cfg_lo_chk;
    ien[SIDE_HI]     = cfg_ie_hi;
    ien[SIDE_LO]     = cfg_ie_lo;
    limit_w[SIDE_HI] = {{PAD_W{1'b0}}, cfg_hi_limit};
    limit_w[SIDE_LO] = {{PAD_W{1'b0}}, cfg_lo_limit};
    clr_sel          = clr_mask & {N_SIDE{clr_stb}};
  end

  adcwm_chan_filter #(.CHAN_W(CHAN_W)) u_filter (
    .valid_i  (res_valid),
    .chan_i   (res_chan),
    .sel_i    (cfg_chan_sel),
    .all_i    (cfg_all_chan),
    .accept_o (accept)
  );

  generate
    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
      adcwm_limit_cmp #(
        .WORD_W (WORD_W),
        .UPPER  (side_is_upper(s))
      ) u_cmp (
        .accept_i (accept),
        .enable_i (chk_en[s]),
        .sample_i (sample_w),
        .limit_i  (limit_w[s]),
        .hit_o    (hit[s])
      );

      adcwm_flag_cell u_flag (
        .clk        (clk),
        .rst        (rst),
        .set_i      (hit[s]),
        .clr_i      (clr_sel[s]),
        .ien_i      (ien[s]),
        .raw_next_o (raw_next[s]),
        .raw_q_o    (raw_q[s]),
        .irq_q_o    (irq_q[s])
      );
    end
  endgenerate

  // The combined line is registered from the same next state, so it keeps
  // the latency of the per-side outputs.
  always_ff @(posedge clk) begin
    if (rst) irq_q_any <= 1'b0;
    else     irq_q_any <= |(raw_next & ien);
  end

  always_comb begin
    raw_hi = raw_q[SIDE_HI];
    raw_lo = raw_q[SIDE_LO];
    irq_hi = irq_q[SIDE_HI];
    irq_lo = irq_q[SIDE_LO];
    irq    = irq_q_any;
  end

  // R6: a result from an unwatched channel changes no flag
  p_unwatched_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !cfg_all_chan && (res_chan != cfg_chan_sel) && !clr_stb)
    |=> $stable({raw_hi, raw_lo}));

  // R12: with no valid result and no clear the flags hold
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !clr_stb) |=> $stable({raw_hi, raw_lo}));

  // R4: a value equal to the upper limit does not raise the upper flag
  p_equal_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_data[DATA_W-1:0] == cfg_hi_limit) && !raw_hi)
    |=> !raw_hi);

  // R5: a disabled lower check never raises the lower flag
  p_lo_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_lo_chk && !raw_lo) |=> !raw_lo);

  // R10: the combined line agrees with the two masked lines
  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_hi || irq_lo));

endmodule

// File: tb/adc_window_monitor_bench.sv
module adc_window_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;
  localparam int N_VEC      = 11;

  // Vector layout: {chan[3:0], data[15:0], all_chan, exp_hi, exp_lo}
  // Fixed setup: upper limit 0xC00, lower limit 0x100, channel 3, both checks on.
  localparam logic [22:0] VEC [N_VEC] = '{
    {4'd3, 16'h0C01, 1'b0, 1'b1, 1'b0},  // R2 just above
    {4'd3, 16'h0C00, 1'b0, 1'b0, 1'b0},  // R4 equal upper
    {4'd3, 16'h00FF, 1'b0, 1'b0, 1'b1},  // R3 just below
    {4'd3, 16'h0100, 1'b0, 1'b0, 1'b0},  // R4 equal lower
    {4'd3, 16'h0800, 1'b0, 1'b0, 1'b0},  // inside window
    {4'd5, 16'h0FFF, 1'b0, 1'b0, 1'b0},  // R6 other channel
    {4'd5, 16'h0FFF, 1'b1, 1'b1, 1'b0},  // R7 all channels
    {4'd0, 16'h0000, 1'b1, 1'b0, 1'b1},  // R7 all channels, low
    {4'd3, 16'hF800, 1'b0, 1'b0, 1'b0},  // R11 top bits set, value inside
    {4'd3, 16'hA0FF, 1'b0, 1'b0, 1'b1},  // R11 top bits set, value low
    {4'd3, 16'h0FFF, 1'b0, 1'b1, 1'b0}   // R2 full scale
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        res_valid;
  logic [3:0]  res_chan;
  logic [15:0] res_data;
  logic [11:0] cfg_hi_limit, cfg_lo_limit;
  logic        cfg_hi_chk, cfg_lo_chk, cfg_all_chan, cfg_ie_hi, cfg_ie_lo;
  logic [3:0]  cfg_chan_sel;
  logic        clr_stb;
  logic [1:0]  clr_mask;
  logic        raw_hi, raw_lo, irq_hi, irq_lo, irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_window_monitor u_adc_window_monitor (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .cfg_hi_limit(cfg_hi_limit), .cfg_lo_limit(cfg_lo_limit),
    .cfg_hi_chk(cfg_hi_chk), .cfg_lo_chk(cfg_lo_chk), .cfg_chan_sel(cfg_chan_sel),
    .cfg_all_chan(cfg_all_chan), .cfg_ie_hi(cfg_ie_hi), .cfg_ie_lo(cfg_ie_lo),
    .clr_stb(clr_stb), .clr_mask(clr_mask), .raw_hi(raw_hi), .raw_lo(raw_lo),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .irq(irq)
  );

  // Compares {irq, irq_hi, irq_lo, raw_hi, raw_lo} with the expected raw flags,
  // deriving the masked lines from the enables as R10 states.
  task automatic check(input string tag, input logic exp_hi, input logic exp_lo);
    logic [4:0] act, exp;
    logic eh, el;
    eh  = exp_hi & cfg_ie_hi;
    el  = exp_lo & cfg_ie_lo;
    exp = {eh | el, eh, el, exp_hi, exp_lo};
    act = {irq, irq_hi, irq_lo, raw_hi, raw_lo};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] ch, input logic [15:0] d);
    res_valid = 1'b1;
    res_chan  = ch;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear(input logic [1:0] m);
    clr_stb  = 1'b1;
    clr_mask = m;
    @(negedge clk);
    clr_stb  = 1'b0;
    clr_mask = 2'b00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=%0d exp<=%0d", cyc, WDOG_LIMIT);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; res_valid = 1'b0; res_chan = '0; res_data = '0;
    cfg_hi_limit = 12'hC00; cfg_lo_limit = 12'h100;
    cfg_hi_chk = 1'b1; cfg_lo_chk = 1'b1; cfg_chan_sel = 4'd3;
    cfg_all_chan = 1'b0; cfg_ie_hi = 1'b1; cfg_ie_lo = 1'b1;
    clr_stb = 1'b0; clr_mask = 2'b00;

    // R1: a violation presented during reset must leave everything at 0
    @(negedge clk);
    res_valid = 1'b1; res_chan = 4'd3; res_data = 16'h0FFF;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0);
    res_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 1'b0, 1'b0);

    // Table walk: R2 R3 R4 R6 R7 R11
    for (int i = 0; i < N_VEC; i++) begin
      clear(2'b11);
      cfg_all_chan = VEC[i][2];
      send(VEC[i][22:19], VEC[i][18:3]);
      check($sformatf("table R2 R3 R4 R6 R7 R11 vec %0d", i), VEC[i][1], VEC[i][0]);
    end
    cfg_all_chan = 1'b0;
    clear(2'b11);

    // R5: disabled checks
    cfg_hi_chk = 1'b0;
    send(4'd3, 16'h0FFF);
    check("R5 upper disabled", 1'b0, 1'b0);
    cfg_hi_chk = 1'b1; cfg_lo_chk = 1'b0;
    send(4'd3, 16'h0000);
    check("R5 lower disabled", 1'b0, 1'b0);
    cfg_lo_chk = 1'b1;

    // R12: result inputs without valid
    res_chan = 4'd3; res_data = 16'h0FFF;
    @(negedge clk);
    check("R12 valid low", 1'b0, 1'b0);

    // R8: stickiness and selective clear
    send(4'd3, 16'h0FFF);
    send(4'd3, 16'h0000);
    check("R8 both set", 1'b1, 1'b1);
    send(4'd3, 16'h0800);
    repeat (3) @(negedge clk);
    check("R8 held", 1'b1, 1'b1);
    clear(2'b01);
    check("R8 clear lower only", 1'b1, 1'b0);
    clear(2'b10);
    check("R8 clear upper", 1'b0, 1'b0);

    // R9: violation and clear on the same edge
    clr_stb = 1'b1; clr_mask = 2'b10;
    send(4'd3, 16'h0FFF);
    clr_stb = 1'b0; clr_mask = 2'b00;
    check("R9 set beats clear", 1'b1, 1'b0);
    clear(2'b11);

    // R10: masking and enable change latency
    cfg_ie_hi = 1'b0;
    send(4'd3, 16'h0D00);
    check("R10 upper masked", 1'b1, 1'b0);
    cfg_ie_hi = 1'b1;
    @(negedge clk);
    check("R10 upper unmasked", 1'b1, 1'b0);
    cfg_ie_lo = 1'b0;
    send(4'd3, 16'h0001);
    check("R10 lower masked", 1'b1, 1'b1);
    cfg_ie_lo = 1'b1;
    @(negedge clk);
    check("R10 both unmasked", 1'b1, 1'b1);

    finish_run();
  end

endmodule